// File: doc/BRIEF.md
# Delay-Select Code Loader with Serial and Parallel Programming

This block owns the code that selects a tap of a programmable delay line. The code can be loaded three ways. A mode pin chooses between the parallel bus and a 3-wire serial port. In parallel mode the enable pin either lets the bus pass straight through (enable held high) or captures the bus when enable falls (enable pulsed).

In serial mode, bits enter an input shift register on rising serial-clock edges while enable is high, most significant bit first. The register's previous contents leave on the serial output in the same order. This lets several units be chained, and it lets the stored code be read back. A readback is destructive, so the value must be shifted back in to keep it. The shifted value becomes the active code only when enable falls.

The serial clock, the enable and all data pins are treated as asynchronous. They are brought into the system clock through a synchronizer and edge-detected there. A one-cycle pulse marks every change of the active code.

Top module: `dly_prog_if`

## Requirements
- R1: While reset is low at a rising clock edge, the active code, the input shift register, the change pulse and the serial output enable all clear to 0 at that edge.
- R2: The design samples its pins at every rising clock edge and acts on a value at the third edge that samples it. While mode=1 and enable=1, the active code copies the parallel bus with that latency.
- R3: With mode=1, the bus value seen together with the first low sample of enable is kept after enable falls. Later bus changes leave the code unchanged while enable stays low.
- R4: With mode=0 and enable high, each rising serial-clock edge shifts the serial input into bit 0 of the input register and moves every bit one place toward bit 7.
- R5: The serial output carries bit 7 of the input register while it is enabled. Bit 7 is present before the first serial-clock edge, and each serial-clock rise presents the next lower old bit, so eight edges return the old byte MSB first.
- R6: In serial mode the active code changes only when enable falls, and it then takes the input register's value. Shifting alone never alters it.
- R7: Serial-clock edges while enable is low, or while mode=1, leave the input register unchanged.
- R8: The serial output enable is high exactly when the synchronized enable is 1 and the synchronized mode is 0, two edges after the pins. While the enable is low, the serial output data is driven 0.
- R9: The change pulse is high for exactly the one cycle in which the active code first shows a new value. It stays low when an update writes the same value.
- R10: A serial readback replaces the stored contents with whatever was shifted in, and that value becomes active when enable falls. Shifting the read byte back in restores the setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 1 | 1 = parallel loading, 0 = serial loading |
| addr_en | input | 1 | Load enable / serial frame enable (asynchronous) |
| sclk | input | 1 | Serial shift clock (asynchronous, sampled) |
| sdin | input | 1 | Serial data in, MSB first |
| par_code | input | 8 | Parallel delay code |
| code_out | output | 8 | Active delay-select code |
| sdout | output | 1 | Serial data out (bit 7 of input register) |
| sdout_oe | output | 1 | Output enable for sdout (tri-state control) |
| code_chg | output | 1 | One-cycle pulse when code_out changes |

## Verification
A corrupted input register is not visible at the ports while it only sits there. It appears on sdout at the next serial frame, as the first bit at once or as a later bit within eight serial-clock edges. It also appears at code_out on the cycle after enable falls. A wrong active code or a wrong edge decision shows up at code_out and code_chg in the same cycle as the faulty update. A bench model that follows every clock therefore catches it within one cycle. A wrong synchronizer depth shows up as a one-cycle shift of every output against the model.

// File: rtl/dpi_pkg.sv
// Shared definitions for the delay-code loader.
// Assumes nothing beyond IEEE 1800-2017 packages.
package dpi_pkg;
    typedef enum logic {
        LD_SERIAL   = 1'b0,
        LD_PARALLEL = 1'b1
    } ld_mode_e;
endpackage

// File: rtl/dpi_sync.sv
// Multi-stage synchronizer with one extra history register for edge detection.
// Assumes each bundled bit is stable around the edges of interest (the
// parallel bus is quasi-static while enable moves).
module dpi_sync #(
    parameter int W      = 12,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    logic [W-1:0] stg [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                // capture the raw pins
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                // pass the sample one stage further
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[gi] <= '0;
                    else        stg[gi] <= stg[gi-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

    // keep the prior synchronized value for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) q_prev <= '0;
        else        q_prev <= q;
    end
endmodule

// File: rtl/dpi_shreg.sv
// Serial input register: shifts MSB-first toward the top bit; top bit is the
// serial output. Assumes shift_en is a one-cycle qualified clock-edge strobe.
module dpi_shreg #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              ser_in,
    output logic [CODE_W-1:0] sreg_q,
    output logic              ser_out
);
    // shift one bit on each qualified serial-clock rise
    always_ff @(posedge clk) begin
        if (!rst_n)        sreg_q <= '0;
        else if (shift_en) sreg_q <= {sreg_q[CODE_W-2:0], ser_in};
    end

    assign ser_out = sreg_q[CODE_W-1];

    assert_shift_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (sreg_q[0] == $past(ser_in)));
endmodule

// File: rtl/dpi_commit.sv
// Active code register: parallel pass-through/latch or serial commit on enable
// fall, plus a one-cycle change strobe. Assumes ae_fall is a one-cycle strobe.
module dpi_commit
    import dpi_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ld_mode_e          ld_mode,
    input  logic              ae_lvl,
    input  logic              ae_fall,
    input  logic [CODE_W-1:0] par_s,
    input  logic [CODE_W-1:0] sreg,
    output logic [CODE_W-1:0] code_q,
    output logic              code_chg
);
    logic [CODE_W-1:0] code_nxt;

    // select the next active code from the current loading mode
    always_comb begin
        code_nxt = code_q;
        unique case (ld_mode)
            LD_PARALLEL: if (ae_lvl || ae_fall) code_nxt = par_s;
            LD_SERIAL:   if (ae_fall)           code_nxt = sreg;
            default:     code_nxt = code_q;
        endcase
    end

    // hold the active code and flag every change of value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q   <= '0;
            code_chg <= 1'b0;
        end else begin
            code_q   <= code_nxt;
            code_chg <= (code_nxt != code_q);
        end
    end

    assert_serial_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_mode == LD_SERIAL && ae_lvl) |=> $stable(code_q));
    assert_chg_marks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        code_chg |-> (code_q != $past(code_q)));
    assert_no_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !code_chg |-> (code_q == $past(code_q)));
endmodule

// File: rtl/dly_prog_if.sv
// Top of the delay-code loader. Synchronizes mode, enable, serial clock,
// serial data and the parallel bus, detects edges, and drives the serial
// register and the active code. Assumes the system clock is several times
// faster than the serial clock and enable pulses.
module dly_prog_if
    import dpi_pkg::*;
#(
    parameter int CODE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel,
    input  logic              addr_en,
    input  logic              sclk,
    input  logic              sdin,
    input  logic [CODE_W-1:0] par_code,
    output logic [CODE_W-1:0] code_out,
    output logic              sdout,
    output logic              sdout_oe,
    output logic              code_chg
);
    localparam int BUS_W = CODE_W + 4;
    localparam int I_SI  = CODE_W;
    localparam int I_SC  = CODE_W + 1;
    localparam int I_AE  = CODE_W + 2;
    localparam int I_MD  = CODE_W + 3;

    logic [BUS_W-1:0]  pin_raw, pin_s, pin_p;
    logic [CODE_W-1:0] sreg;
    logic              ser_bit, ae_lvl, ae_fall, sc_rise, shift_en;
    ld_mode_e          ld_mode;

    assign pin_raw = {mode_sel, addr_en, sclk, sdin, par_code};

    dpi_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d      (pin_raw),
        .q      (pin_s),
        .q_prev (pin_p)
    );

    // decode synchronized levels and edges
    always_comb begin
        ld_mode  = pin_s[I_MD] ? LD_PARALLEL : LD_SERIAL;
        ae_lvl   = pin_s[I_AE];
        ae_fall  = !pin_s[I_AE] && pin_p[I_AE];
        sc_rise  = pin_s[I_SC] && !pin_p[I_SC];
        shift_en = sc_rise && ae_lvl && (ld_mode == LD_SERIAL);
    end

    dpi_shreg #(.CODE_W(CODE_W)) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .ser_in   (pin_s[I_SI]),
        .sreg_q   (sreg),
        .ser_out  (ser_bit)
    );

    dpi_commit #(.CODE_W(CODE_W)) u_commit (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_mode  (ld_mode),
        .ae_lvl   (ae_lvl),
        .ae_fall  (ae_fall),
        .par_s    (pin_s[CODE_W-1:0]),
        .sreg     (sreg),
        .code_q   (code_out),
        .code_chg (code_chg)
    );

    // serial output drives only inside a serial frame
    always_comb begin
        sdout_oe = ae_lvl && (ld_mode == LD_SERIAL);
        sdout    = sdout_oe && ser_bit;
    end

    assert_idle_sc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_rise && !ae_lvl) |=> $stable(sreg));
    assert_quiet_so_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sdout_oe |-> !sdout);
    assert_par_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_s[I_MD] && ae_lvl) |=> (code_out == $past(pin_s[CODE_W-1:0])));
endmodule

// File: tb/dly_prog_if_tb_top.sv
`timescale 1ns/1ps
// Bench: drives pins at the falling edge, runs a behavioural model at the
// rising edge and compares every output at the next falling edge.
module dly_prog_if_tb_top;
    typedef struct packed {
        logic       md;
        logic       ae;
        logic       sc;
        logic       si;
        logic [7:0] par;
    } pin_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_sel = 1'b0, addr_en = 1'b0, sclk = 1'b0, sdin = 1'b0;
    logic [7:0] par_code = 8'h00;
    logic [7:0] code_out;
    logic       sdout, sdout_oe, code_chg;

    int    n_vec = 0, n_bad = 0;
    bit    started = 0, done = 0;
    string tag = "R1";

    pin_t       hist [3];
    logic [7:0] m_sreg = 0, m_code = 0;
    logic       m_chg = 0, m_oe = 0;

    always #10 clk = ~clk;

    dly_prog_if dut_i (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .addr_en(addr_en),
        .sclk(sclk), .sdin(sdin), .par_code(par_code), .code_out(code_out),
        .sdout(sdout), .sdout_oe(sdout_oe), .code_chg(code_chg)
    );

    // behavioural model: pins act two sampling edges late, edges seen vs. one older sample
    always @(posedge clk) begin
        pin_t now_p, cur, prv;
        logic [7:0] old_code;
        now_p = '{md: mode_sel, ae: addr_en, sc: sclk, si: sdin, par: par_code};
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) hist[i] = '0;
            m_sreg = 0; m_code = 0; m_chg = 0; m_oe = 0;
        end else begin
            cur = hist[1];
            prv = hist[2];
            old_code = m_code;
            if (!cur.md && cur.ae && cur.sc && !prv.sc) m_sreg = {m_sreg[6:0], cur.si};
            if (!cur.md && !cur.ae && prv.ae)           m_code = m_sreg;
            if (cur.md && (cur.ae || prv.ae))           m_code = cur.par;
            m_chg = (m_code != old_code);
            hist[2] = hist[1];
            hist[1] = hist[0];
            hist[0] = now_p;
            m_oe = hist[1].ae && !hist[1].md;
        end
        started = 1;
    end

    task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp_v);
        n_vec++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s t=%0t actual=%h expected=%h", rq, $time, act, exp_v);
        end
    endtask

    // compare every output against the model each cycle
    always @(negedge clk) begin
        if (started && !done) begin
            chk(tag,  code_out, m_code);
            chk("R9", {7'b0, code_chg}, {7'b0, m_chg});
            chk("R8", {7'b0, sdout_oe}, {7'b0, m_oe});
            chk("R5", {7'b0, sdout}, {7'b0, m_oe & m_sreg[7]});
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one serial frame: returns the bits seen on sdout before each clock rise
    task automatic ser_frame(input logic [7:0] wr, output logic [7:0] rd);
        mode_sel = 1'b0; addr_en = 1'b1; wait_n(4);
        for (int i = 7; i >= 0; i--) begin
            sdin = wr[i]; wait_n(3);
            rd[i] = sdout;
            sclk = 1'b1; wait_n(3);
            sclk = 1'b0;
        end
        wait_n(3);
        addr_en = 1'b0; wait_n(5);
    endtask

    task automatic summary;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #3000000;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [7:0] rd;
        wait_n(3);
        chk("R1", code_out, 8'h00);
        chk("R1", {6'b0, sdout_oe, code_chg}, 8'h00);
        rst_n = 1'b1; wait_n(2);

        tag = "R4"; ser_frame(8'hA5, rd);
        chk("R6", code_out, 8'hA5);
        chk("R5", rd, 8'h00);
        tag = "R5"; ser_frame(8'h3C, rd);
        chk("R5", rd, 8'hA5);
        chk("R6", code_out, 8'h3C);

        tag = "R7"; mode_sel = 1'b0; sdin = 1'b1;
        for (int k = 0; k < 5; k++) begin sclk = 1'b1; wait_n(3); sclk = 1'b0; wait_n(3); end
        tag = "R10"; ser_frame(8'h00, rd);
        chk("R7", rd, 8'h3C);
        chk("R10", code_out, 8'h00);
        ser_frame(rd, rd);
        chk("R10", code_out, 8'h3C);

        tag = "R2"; mode_sel = 1'b1; addr_en = 1'b1;
        foreach (rd[b]) begin par_code = 8'h1 << b; wait_n(4); chk("R2", code_out, 8'h1 << b); end
        par_code = 8'hFF; wait_n(4); chk("R2", code_out, 8'hFF);
        par_code = 8'hFF; wait_n(4);
        par_code = 8'h00; wait_n(4); chk("R2", code_out, 8'h00);

        tag = "R3"; addr_en = 1'b0; wait_n(4);
        par_code = 8'h5A; wait_n(5); chk("R3", code_out, 8'h00);
        addr_en = 1'b1; wait_n(4); par_code = 8'h81; wait_n(4);
        addr_en = 1'b0; wait_n(4); par_code = 8'h42; wait_n(5);
        chk("R3", code_out, 8'h81);
        sdin = 1'b0;
        for (int k = 0; k < 3; k++) begin sclk = 1'b1; wait_n(3); sclk = 1'b0; wait_n(3); end

        tag = "R7"; ser_frame(8'h3C, rd);
        chk("R7", rd, 8'h3C);
        chk("R9", code_out, 8'h3C);
        wait_n(5);
        summary();
    end
endmodule